// File: doc/BRIEF.md
# Halt-Mode Critical Interrupt Gate

This block sits between the interrupt request lines and the core's interrupt dispatch. When a debugger halts the application, only the request lines marked as time-critical in a programmable mask keep reaching dispatch. Every other line is held back. A request on a held-back line is remembered in a sticky pending bit and is handed to dispatch once the debugger resumes. A trace-qualify output is high only while critical code is being serviced under halt, so a trace taken during the halt records only that code.

Software writes the critical mask through a one-cycle write strobe. The mask changes only while the application runs. A write made during a halt is dropped and raises an error pulse. All outputs are registered. Each output reflects the run/halt state that applies in the same cycle.

Top module: `crit_irq_gate`

## Requirements
- R1: After reset, app_run is 1, and dispatch_en, pend_vec, trace_qual and mask_wr_err are 0. The critical mask is cleared to all zeros.
- R2: app_run falls the cycle after halt_req and rises the cycle after resume_req. When halt_req and resume_req are asserted in the same cycle, halt wins.
- R3: While halted, a request on line n with mask bit n = 1 appears on dispatch_en bit n the cycle after the request.
- R4: While halted, dispatch_en bit n stays 0 for every line whose mask bit n is 0.
- R5: A request during halt on a line with mask bit 0 sets pend_vec bit n the next cycle. The bit stays set after the request drops.
- R6: While running, dispatch_en equals irq_req OR pend_vec, one cycle later.
- R7: An irq_ack bit clears the matching pend_vec bit on the next cycle. If the same bit is being set in that cycle, the set wins.
- R8: trace_qual is 1 only in cycles where the gate is halted and at least one critical line is forwarded on dispatch_en.
- R9: A mask write while running takes effect on the next cycle. A mask write while halted leaves the mask unchanged and pulses mask_wr_err for one cycle.
- R10: Mask bit position n controls request line n and dispatch_en bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Debug halt request |
| resume_req | input | 1 | Debug resume request |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_ack | input | NUM_IRQ | Dispatch acknowledge, clears pending bits |
| mask_wr_en | input | 1 | Critical mask write strobe |
| mask_wr_data | input | NUM_IRQ | Critical mask write value |
| dispatch_en | output | NUM_IRQ | Per-line enable toward dispatch |
| app_run | output | 1 | Application context is running |
| pend_vec | output | NUM_IRQ | Latched non-critical requests |
| trace_qual | output | 1 | Trace qualify during critical service under halt |
| mask_wr_err | output | 1 | Pulse for a mask write dropped during halt |

## Verification
The hardest case to reach from the ports is the collision of an acknowledge with a fresh pending set on the same line. The gate must already be halted, the line must be non-critical, and the request and acknowledge must arrive in the same cycle. The vector table reaches this state by programming a one-bit mask while running and then halting. It then drives the request and acknowledge together, resumes, and confirms that the pending bit survived and is dispatched. The rejection of a mask write made during halt is proven through behaviour: after the rejected write, a line that would have become critical must still be blocked.

// File: rtl/crit_gate_pkg.sv
package crit_gate_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } gate_state_e;
endpackage

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import crit_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic resume_req,
  output logic halted,
  output logic halted_nxt,
  output logic app_run
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (halt_req)
      state_d = ST_HALT;
    else if (resume_req)
      state_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      app_run <= 1'b1;
    end else begin
      state_q <= state_d;
      app_run <= (state_d == ST_RUN);
    end
  end

  assign halted     = (state_q == ST_HALT);
  assign halted_nxt = (state_d == ST_HALT);

  // R2
  halt_to_stop_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !app_run);

  // R2
  resume_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    (resume_req && !halt_req) |=> app_run);
endmodule

// File: rtl/crit_mask_reg.sv
module crit_mask_reg #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halted,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wr_data,
  output logic [NUM_IRQ-1:0] mask,
  output logic               wr_err
);
  logic wr_ok;
  assign wr_ok = wr_en && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      wr_err <= 1'b0;
    end else begin
      if (wr_ok)
        mask <= wr_data;
      wr_err <= wr_en && halted;
    end
  end

  // R9
  mask_frozen_in_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mask));
endmodule

// File: rtl/pend_latch.sv
module pend_latch #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halted_nxt,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] ack,
  output logic [NUM_IRQ-1:0] pend
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic set_i;
    assign set_i = halted_nxt && irq[i] && !mask[i];
    always_ff @(posedge clk) begin
      if (rst)
        pend[i] <= 1'b0;
      else if (set_i)
        pend[i] <= 1'b1;
      else if (ack[i])
        pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halted_nxt,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] pend,
  output logic [NUM_IRQ-1:0] dispatch_en,
  output logic               trace_qual
);
  logic [NUM_IRQ-1:0] crit_hit;
  logic [NUM_IRQ-1:0] en_d;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign crit_hit[i] = irq[i] && mask[i];
    assign en_d[i]     = halted_nxt ? crit_hit[i] : (irq[i] || pend[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dispatch_en <= '0;
      trace_qual  <= 1'b0;
    end else begin
      dispatch_en <= en_d;
      trace_qual  <= halted_nxt && (|crit_hit);
    end
  end
endmodule

// File: rtl/crit_irq_gate.sv
module crit_irq_gate #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic               resume_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_ack,
  input  logic               mask_wr_en,
  input  logic [NUM_IRQ-1:0] mask_wr_data,
  output logic [NUM_IRQ-1:0] dispatch_en,
  output logic               app_run,
  output logic [NUM_IRQ-1:0] pend_vec,
  output logic               trace_qual,
  output logic               mask_wr_err
);
  logic               halted;
  logic               halted_nxt;
  logic [NUM_IRQ-1:0] crit_mask;

  halt_ctrl u_halt (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .resume_req (resume_req),
    .halted     (halted),
    .halted_nxt (halted_nxt),
    .app_run    (app_run)
  );

  crit_mask_reg #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .halted  (halted),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask    (crit_mask),
    .wr_err  (mask_wr_err)
  );

  pend_latch #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .halted_nxt (halted_nxt),
    .irq        (irq_req),
    .mask       (crit_mask),
    .ack        (irq_ack),
    .pend       (pend_vec)
  );

  dispatch_gate #(.NUM_IRQ(NUM_IRQ)) u_disp (
    .clk         (clk),
    .rst         (rst),
    .halted_nxt  (halted_nxt),
    .irq         (irq_req),
    .mask        (crit_mask),
    .pend        (pend_vec),
    .dispatch_en (dispatch_en),
    .trace_qual  (trace_qual)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (app_run && pend_vec == '0 && dispatch_en == '0 && !trace_qual));

  // R4
  noncrit_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !app_run |-> ((dispatch_en & ~$past(crit_mask)) == '0));

  // R5
  pend_rise_in_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend_vec & ~$past(pend_vec))) |-> !app_run);

  // R8
  trace_only_crit_chk: assert property (@(posedge clk) disable iff (rst)
    trace_qual |-> (!app_run && (|dispatch_en)));

  // R9
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr_err |-> $past(mask_wr_en && !app_run));
endmodule

// File: tb/sim_crit_irq_gate.sv
module sim_crit_irq_gate;
  localparam int N = 8;

  typedef struct packed {
    logic       hlt;
    logic       res;
    logic [7:0] irq;
    logic [7:0] ack;
    logic       wr;
    logic [7:0] wd;
    logic       run;
    logic [7:0] disp;
    logic [7:0] pend;
    logic       tq;
    logic       err;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    // hlt res irq    ack    wr  wd     run disp   pend   tq  err req
    '{1'b0,1'b0,8'h00,8'h00,1'b1,8'h05,1'b1,8'h00,8'h00,1'b0,1'b0,4'd9},  // R9 write while running
    '{1'b0,1'b0,8'h12,8'h00,1'b0,8'h00,1'b1,8'h12,8'h00,1'b0,1'b0,4'd6},  // R6 pass-through
    '{1'b1,1'b0,8'h03,8'h00,1'b0,8'h00,1'b0,8'h01,8'h02,1'b1,1'b0,4'd3},  // R3 R4 R5 R8 halt
    '{1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b0,8'h00,8'h02,1'b0,1'b0,4'd5},  // R5 sticky
    '{1'b0,1'b0,8'h84,8'h00,1'b0,8'h00,1'b0,8'h04,8'h82,1'b1,1'b0,4'd10}, // R10 bit positions
    '{1'b0,1'b0,8'h00,8'h00,1'b1,8'hFF,1'b0,8'h00,8'h82,1'b0,1'b1,4'd9},  // R9 write in halt
    '{1'b0,1'b0,8'h80,8'h00,1'b0,8'h00,1'b0,8'h00,8'h82,1'b0,1'b0,4'd9},  // R9 mask unchanged
    '{1'b1,1'b1,8'h00,8'h00,1'b0,8'h00,1'b0,8'h00,8'h82,1'b0,1'b0,4'd2},  // R2 halt wins
    '{1'b0,1'b1,8'h00,8'h00,1'b0,8'h00,1'b1,8'h82,8'h82,1'b0,1'b0,4'd6},  // R6 pending released
    '{1'b0,1'b0,8'h00,8'h02,1'b0,8'h00,1'b1,8'h82,8'h80,1'b0,1'b0,4'd7},  // R7 ack
    '{1'b0,1'b0,8'h00,8'h80,1'b0,8'h00,1'b1,8'h80,8'h00,1'b0,1'b0,4'd7},  // R7 ack
    '{1'b0,1'b0,8'h00,8'h00,1'b0,8'h00,1'b1,8'h00,8'h00,1'b0,1'b0,4'd6},  // R6 idle
    '{1'b0,1'b0,8'h00,8'h00,1'b1,8'h01,1'b1,8'h00,8'h00,1'b0,1'b0,4'd9},  // R9 rewrite
    '{1'b1,1'b0,8'h04,8'h00,1'b0,8'h00,1'b0,8'h00,8'h04,1'b0,1'b0,4'd4},  // R4 R8 no trace
    '{1'b0,1'b0,8'h04,8'h04,1'b0,8'h00,1'b0,8'h00,8'h04,1'b0,1'b0,4'd7},  // R7 set wins
    '{1'b0,1'b1,8'h00,8'h00,1'b0,8'h00,1'b1,8'h04,8'h04,1'b0,1'b0,4'd2},  // R2 resume
    '{1'b0,1'b0,8'h00,8'h04,1'b0,8'h00,1'b1,8'h04,8'h00,1'b0,1'b0,4'd7}   // R7 final ack
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         halt_req = 1'b0, resume_req = 1'b0, mask_wr_en = 1'b0;
  logic [N-1:0] irq_req = '0, irq_ack = '0, mask_wr_data = '0;
  logic [N-1:0] dispatch_en, pend_vec;
  logic         app_run, trace_qual, mask_wr_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crit_irq_gate #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst(rst), .halt_req(halt_req), .resume_req(resume_req),
    .irq_req(irq_req), .irq_ack(irq_ack), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .dispatch_en(dispatch_en), .app_run(app_run),
    .pend_vec(pend_vec), .trace_qual(trace_qual), .mask_wr_err(mask_wr_err)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic h, input logic r, input logic [N-1:0] i,
                       input logic [N-1:0] a, input logic w, input logic [N-1:0] d);
    @(negedge clk);
    halt_req = h; resume_req = r; irq_req = i; irq_ack = a;
    mask_wr_en = w; mask_wr_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(1, "app_run", {31'd0, app_run}, 32'd1);
    check(1, "dispatch_en", {24'd0, dispatch_en}, 32'd0);
    check(1, "pend_vec", {24'd0, pend_vec}, 32'd0);
    check(1, "trace_qual", {31'd0, trace_qual}, 32'd0);
    check(1, "mask_wr_err", {31'd0, mask_wr_err}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VT[k].hlt, VT[k].res, VT[k].irq, VT[k].ack, VT[k].wr, VT[k].wd);
      check(int'(VT[k].req), $sformatf("vec%0d app_run", k), {31'd0, app_run}, {31'd0, VT[k].run});
      check(int'(VT[k].req), $sformatf("vec%0d dispatch_en", k), {24'd0, dispatch_en}, {24'd0, VT[k].disp});
      check(int'(VT[k].req), $sformatf("vec%0d pend_vec", k), {24'd0, pend_vec}, {24'd0, VT[k].pend});
      check(int'(VT[k].req), $sformatf("vec%0d trace_qual", k), {31'd0, trace_qual}, {31'd0, VT[k].tq});
      check(int'(VT[k].req), $sformatf("vec%0d mask_wr_err", k), {31'd0, mask_wr_err}, {31'd0, VT[k].err});
    end

    // R1 reset in the middle of a halt with pending state and a nonzero mask
    drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hF0);
    drive(1'b1, 1'b0, 8'h0F, 8'h00, 1'b0, 8'h00);
    check(5, "pend before reset", {24'd0, pend_vec}, 32'h0F);
    @(negedge clk);
    rst = 1'b1; halt_req = 1'b0; irq_req = '0;
    @(posedge clk); #1;
    check(1, "app_run after reset", {31'd0, app_run}, 32'd1);
    check(1, "pend after reset", {24'd0, pend_vec}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    // R1 mask cleared: under halt, line 7 is no longer critical
    drive(1'b1, 1'b0, 8'h80, 8'h00, 1'b0, 8'h00);
    check(1, "mask cleared dispatch", {24'd0, dispatch_en}, 32'd0);
    check(1, "mask cleared pend", {24'd0, pend_vec}, 32'h80);
    check(8, "no trace without critical", {31'd0, trace_qual}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule